// File: doc/BRIEF.md
# Interleaved Multi-Context Issue Scheduler

This block decides, on every clock, which of several architectural processor contexts may place an instruction into a shared, deep, in-order pipeline. Each context holds a program counter and one of three states: runnable, parked on a memory miss, or handed off to a software host because decode met an instruction that the hardware does not implement. The scheduler offers one context id and its program counter per cycle. Selection rotates round-robin, starting after the context that issued last. A context that is parked, or that issued too recently to be clear of the pipeline, is passed over. When no context qualifies, the offer is a bubble.

Only the pipeline front end talks to the block through a valid/ready pair. The scheduler raises `issue_valid` whenever a context qualifies. An instruction transfers only on a cycle with both `issue_valid` and `issue_ready` high. While `issue_ready` is low, the rotation pointer and every program counter hold still, but the spacing timers keep counting. The offered context may therefore change from one cycle to the next before a transfer, and the pipeline must not rely on the offer staying stable. Park requests and completion events are single-cycle pulses on plain pins. Each carries a context id, and the scheduler takes it on any cycle. Because a context can never have two instructions in flight, the pipeline needs no forwarding or interlock logic.

Top module: `ctxsched_top`

## Requirements
- R1: On reset, every context is runnable with program counter `RESET_PC` (0). `issue_valid` stays low while reset is held. After release, the first offer is context 0.
- R2: The offer is the first qualifying context found by scanning upward, with wraparound, from the context after the last one that transferred. A context qualifies only if it is runnable, has finished its spacing window and is not being parked this cycle. When none qualifies, `issue_valid` is low.
- R3: A context that transfers at cycle t is not offered again before cycle t+`PIPE_DEPTH` (14). Two consecutive transfers therefore never name the same context.
- R4: Each transfer advances the issuing context's program counter by `PC_STEP` (4) bytes.
- R5: A memory-wait request moves the named context to state 01 (memory-wait) and loads its program counter with `mw_req_pc`. The context is not offered again until a memory completion names it. From the cycle after that completion it is runnable.
- R6: A transplant request moves the named context to state 10 (hosted) and loads its program counter with `xp_req_pc`. A host return naming it makes it runnable again from the next cycle, resuming at `host_ret_pc`. A transplant and a memory-wait request naming the same context in the same cycle is a protocol violation.
- R7: A completion that does not match the context's state is ignored, and the context's state and program counter are left unchanged. This covers a memory completion for a runnable or hosted context and a host return for a runnable or memory-wait context.
- R8: A context named by a park request in a cycle is not offered in that same cycle.
- R9: With `issue_ready` low, nothing transfers, and neither the rotation pointer nor any program counter changes. The spacing windows still elapse.
- R10: When a park request and a completion name the same context in the same cycle, the park request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | output | 1 | A qualifying context is offered |
| issue_ready | input | 1 | Pipeline accepts the offer this cycle |
| issue_ctx | output | CTX_W (4) | Offered context id |
| issue_pc | output | PC_W (32) | Program counter of the offered context |
| mw_req_valid | input | 1 | Park a context on a memory miss |
| mw_req_ctx | input | CTX_W | Context to park for memory |
| mw_req_pc | input | PC_W | Resume address for the memory-parked context |
| xp_req_valid | input | 1 | Hand a context off to the software host |
| xp_req_ctx | input | CTX_W | Context to hand off |
| xp_req_pc | input | PC_W | Program counter recorded at handoff |
| mem_done_valid | input | 1 | Memory completion event |
| mem_done_ctx | input | CTX_W | Context whose miss completed |
| host_ret_valid | input | 1 | Software host hands a context back |
| host_ret_ctx | input | CTX_W | Context returned by the host |
| host_ret_pc | input | PC_W | Resume address given by the host |

## Verification
A wrong context state shows up at the issue port within one rotation of the context ring. A context left parked by mistake disappears from the offer sequence. A context that is released too early appears in a slot where the scan should have passed it over. A stale program counter or spacing timer is visible on the next offer for that context: either the address differs or the offer comes sooner than `PIPE_DEPTH` cycles. A drifted rotation pointer changes the very next offered id. For these reasons the offer, id and address are compared against an independent model on every cycle, under back-pressure and while events arrive on every input.

// File: rtl/ctxsched_pkg.sv
package ctxsched_pkg;

  // Per-context scheduling state; encodings are part of the block's contract.
  typedef enum logic [1:0] {
    CTX_RUN     = 2'b00,
    CTX_MEMWAIT = 2'b01,
    CTX_HOSTED  = 2'b10
  } ctx_state_e;

endpackage

// File: rtl/ctxsched_event_dec.sv
module ctxsched_event_dec #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic          ev_valid,
  input  logic [IW-1:0] ev_id,
  output logic [N-1:0]  ev_onehot
);

  // Expand an (id, valid) event into one strobe per context.
  always_comb begin
    ev_onehot = '0;
    if (ev_valid && (int'(ev_id) < N)) begin
      ev_onehot[ev_id] = 1'b1;
    end
  end

endmodule

// File: rtl/ctxsched_rr_pick.sv
module ctxsched_rr_pick #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  cand,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] sel
);

  // Scan from the slot after the last winner, wrapping once round the ring.
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last) + k) % N;
      if (!found && cand[idx]) begin
        found = 1'b1;
        sel   = idx[IW-1:0];
      end
    end
  end

endmodule

// File: rtl/ctxsched_slot.sv
module ctxsched_slot
  import ctxsched_pkg::*;
#(
  parameter int          PC_W      = 32,
  parameter int          PC_STEP   = 4,
  parameter logic [31:0] RESET_PC  = 32'h0,
  parameter int          COOL_W    = 4,
  parameter int          COOL_LOAD = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_hit,
  input  logic            mw_hit,
  input  logic            xp_hit,
  input  logic            done_hit,
  input  logic            ret_hit,
  input  logic [PC_W-1:0] park_pc,
  input  logic [PC_W-1:0] ret_pc,
  output logic            eligible,
  output logic [PC_W-1:0] pc
);

  localparam logic [COOL_W-1:0] COOL_INIT = COOL_W'(COOL_LOAD);
  localparam logic [PC_W-1:0]   PC_INC    = PC_W'(PC_STEP);

  ctx_state_e        state_q, state_d;
  logic [PC_W-1:0]   pc_q, pc_d;
  logic [COOL_W-1:0] cool_q, cool_d;

  // State: park requests outrank completions; a completion only acts
  // when it matches the kind of wait the context is in.
  always_comb begin
    state_d = state_q;
    if (xp_hit) begin
      state_d = CTX_HOSTED;
    end else if (mw_hit) begin
      state_d = CTX_MEMWAIT;
    end else if (done_hit && (state_q == CTX_MEMWAIT)) begin
      state_d = CTX_RUN;
    end else if (ret_hit && (state_q == CTX_HOSTED)) begin
      state_d = CTX_RUN;
    end
  end

  always_comb begin
    pc_d = pc_q;
    if (xp_hit || mw_hit) begin
      pc_d = park_pc;
    end else if (ret_hit && (state_q == CTX_HOSTED)) begin
      pc_d = ret_pc;
    end else if (issue_hit) begin
      pc_d = pc_q + PC_INC;
    end
  end

  // Spacing window: reloaded on issue, counts down every cycle.
  always_comb begin
    cool_d = cool_q;
    if (issue_hit) begin
      cool_d = COOL_INIT;
    end else if (cool_q != '0) begin
      cool_d = cool_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CTX_RUN;
      pc_q    <= RESET_PC[PC_W-1:0];
      cool_q  <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      cool_q  <= cool_d;
    end
  end

  assign eligible = (state_q == CTX_RUN) && (cool_q == '0) && !mw_hit && !xp_hit;
  assign pc       = pc_q;

endmodule

// File: rtl/ctxsched_top.sv
module ctxsched_top #(
  parameter int          NUM_CTX    = 16,
  parameter int          PIPE_DEPTH = 14,
  parameter int          PC_W       = 32,
  parameter int          PC_STEP    = 4,
  parameter logic [31:0] RESET_PC   = 32'h0,
  localparam int         CTX_W      = $clog2(NUM_CTX)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             issue_valid,
  input  logic             issue_ready,
  output logic [CTX_W-1:0] issue_ctx,
  output logic [PC_W-1:0]  issue_pc,
  input  logic             mw_req_valid,
  input  logic [CTX_W-1:0] mw_req_ctx,
  input  logic [PC_W-1:0]  mw_req_pc,
  input  logic             xp_req_valid,
  input  logic [CTX_W-1:0] xp_req_ctx,
  input  logic [PC_W-1:0]  xp_req_pc,
  input  logic             mem_done_valid,
  input  logic [CTX_W-1:0] mem_done_ctx,
  input  logic             host_ret_valid,
  input  logic [CTX_W-1:0] host_ret_ctx,
  input  logic [PC_W-1:0]  host_ret_pc
);

  localparam int COOL_W    = (PIPE_DEPTH > 2) ? $clog2(PIPE_DEPTH) : 1;
  localparam int COOL_LOAD = (PIPE_DEPTH > 1) ? PIPE_DEPTH - 1 : 0;
  localparam logic [CTX_W-1:0] LAST_INIT = CTX_W'(NUM_CTX - 1);

  logic [NUM_CTX-1:0] mw_oh, xp_oh, done_oh, ret_oh, issue_oh;
  logic [NUM_CTX-1:0] slot_elig;
  logic [PC_W-1:0]    slot_pc [NUM_CTX];
  logic [CTX_W-1:0]   last_q;
  logic               pick_found;
  logic [CTX_W-1:0]   pick_sel;
  logic               issue_fire;

  ctxsched_event_dec #(.N(NUM_CTX), .IW(CTX_W)) u_dec_mw (
    .ev_valid(mw_req_valid), .ev_id(mw_req_ctx), .ev_onehot(mw_oh));
  ctxsched_event_dec #(.N(NUM_CTX), .IW(CTX_W)) u_dec_xp (
    .ev_valid(xp_req_valid), .ev_id(xp_req_ctx), .ev_onehot(xp_oh));
  ctxsched_event_dec #(.N(NUM_CTX), .IW(CTX_W)) u_dec_done (
    .ev_valid(mem_done_valid), .ev_id(mem_done_ctx), .ev_onehot(done_oh));
  ctxsched_event_dec #(.N(NUM_CTX), .IW(CTX_W)) u_dec_ret (
    .ev_valid(host_ret_valid), .ev_id(host_ret_ctx), .ev_onehot(ret_oh));
  ctxsched_event_dec #(.N(NUM_CTX), .IW(CTX_W)) u_dec_issue (
    .ev_valid(issue_fire), .ev_id(pick_sel), .ev_onehot(issue_oh));

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    ctxsched_slot #(
      .PC_W     (PC_W),
      .PC_STEP  (PC_STEP),
      .RESET_PC (RESET_PC),
      .COOL_W   (COOL_W),
      .COOL_LOAD(COOL_LOAD)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .issue_hit(issue_oh[c]),
      .mw_hit   (mw_oh[c]),
      .xp_hit   (xp_oh[c]),
      .done_hit (done_oh[c]),
      .ret_hit  (ret_oh[c]),
      .park_pc  (xp_oh[c] ? xp_req_pc : mw_req_pc),
      .ret_pc   (host_ret_pc),
      .eligible (slot_elig[c]),
      .pc       (slot_pc[c])
    );
  end

  ctxsched_rr_pick #(.N(NUM_CTX), .IW(CTX_W)) u_pick (
    .cand (slot_elig),
    .last (last_q),
    .found(pick_found),
    .sel  (pick_sel)
  );

  assign issue_valid = rst_n && pick_found;
  assign issue_ctx   = pick_sel;
  assign issue_pc    = slot_pc[pick_sel];
  assign issue_fire  = issue_valid && issue_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= LAST_INIT;
    end else if (issue_fire) begin
      last_q <= pick_sel;
    end
  end

endmodule

// File: rtl/ctxsched_chk.sv
module ctxsched_chk #(
  parameter int NUM_CTX    = 16,
  parameter int PIPE_DEPTH = 14,
  parameter int CTX_W      = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue_valid,
  input logic             issue_ready,
  input logic [CTX_W-1:0] issue_ctx,
  input logic             mw_req_valid,
  input logic [CTX_W-1:0] mw_req_ctx,
  input logic             xp_req_valid,
  input logic [CTX_W-1:0] xp_req_ctx,
  input logic             mem_done_valid,
  input logic [CTX_W-1:0] mem_done_ctx,
  input logic             host_ret_valid,
  input logic [CTX_W-1:0] host_ret_ctx
);

  localparam int GAP_W = $clog2(PIPE_DEPTH + 1);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(PIPE_DEPTH);

  logic             fire;
  logic [GAP_W-1:0] gap   [NUM_CTX];
  logic [NUM_CTX-1:0] mem_blk, host_blk;

  assign fire = issue_valid && issue_ready;

  // Cycles since each context last transferred, saturating at the depth.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CTX; c++) gap[c] <= GAP_MAX;
    end else begin
      for (int c = 0; c < NUM_CTX; c++) begin
        if (fire && (int'(issue_ctx) == c)) gap[c] <= GAP_W'(1);
        else if (gap[c] < GAP_MAX)          gap[c] <= gap[c] + 1'b1;
      end
    end
  end

  // Parked contexts as seen from the event pins alone.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_blk  <= '0;
      host_blk <= '0;
    end else begin
      for (int c = 0; c < NUM_CTX; c++) begin
        if (xp_req_valid && (int'(xp_req_ctx) == c)) begin
          mem_blk[c]  <= 1'b0;
          host_blk[c] <= 1'b1;
        end else if (mw_req_valid && (int'(mw_req_ctx) == c)) begin
          mem_blk[c]  <= 1'b1;
          host_blk[c] <= 1'b0;
        end else begin
          if (mem_done_valid && (int'(mem_done_ctx) == c)) mem_blk[c]  <= 1'b0;
          if (host_ret_valid && (int'(host_ret_ctx) == c)) host_blk[c] <= 1'b0;
        end
      end
    end
  end

  AST_ISSUE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (gap[issue_ctx] >= GAP_MAX)); // R3

  AST_NO_REPEAT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && $past(fire)) |-> (issue_ctx != $past(issue_ctx))); // R3

  AST_PARKED_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> !(mem_blk[issue_ctx] || host_blk[issue_ctx])); // R5

  AST_PARK_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> !((mw_req_valid && mw_req_ctx == issue_ctx) ||
                      (xp_req_valid && xp_req_ctx == issue_ctx))); // R8

  AST_SINGLE_PARK_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(mw_req_valid && xp_req_valid && (mw_req_ctx == xp_req_ctx))); // R6

endmodule

bind ctxsched_top ctxsched_chk #(
  .NUM_CTX   (NUM_CTX),
  .PIPE_DEPTH(PIPE_DEPTH),
  .CTX_W     (CTX_W)
) i_ctxsched_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .issue_valid   (issue_valid),
  .issue_ready   (issue_ready),
  .issue_ctx     (issue_ctx),
  .mw_req_valid  (mw_req_valid),
  .mw_req_ctx    (mw_req_ctx),
  .xp_req_valid  (xp_req_valid),
  .xp_req_ctx    (xp_req_ctx),
  .mem_done_valid(mem_done_valid),
  .mem_done_ctx  (mem_done_ctx),
  .host_ret_valid(host_ret_valid),
  .host_ret_ctx  (host_ret_ctx)
);

// File: tb/test_ctxsched_top.sv
module test_ctxsched_top;

  localparam int N    = 16;
  localparam int D    = 14;
  localparam int PCW  = 32;
  localparam int STEP = 4;
  localparam int IW   = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           issue_valid, issue_ready;
  logic [IW-1:0]  issue_ctx;
  logic [PCW-1:0] issue_pc;
  logic           mw_req_valid, xp_req_valid, mem_done_valid, host_ret_valid;
  logic [IW-1:0]  mw_req_ctx, xp_req_ctx, mem_done_ctx, host_ret_ctx;
  logic [PCW-1:0] mw_req_pc, xp_req_pc, host_ret_pc;

  always #4 clk = ~clk;  // 125 MHz

  ctxsched_top i_ctxsched_top (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_ctx(issue_ctx), .issue_pc(issue_pc),
    .mw_req_valid(mw_req_valid), .mw_req_ctx(mw_req_ctx), .mw_req_pc(mw_req_pc),
    .xp_req_valid(xp_req_valid), .xp_req_ctx(xp_req_ctx), .xp_req_pc(xp_req_pc),
    .mem_done_valid(mem_done_valid), .mem_done_ctx(mem_done_ctx),
    .host_ret_valid(host_ret_valid), .host_ret_ctx(host_ret_ctx),
    .host_ret_pc(host_ret_pc)
  );

  // Stimulus requested for the next cycle (events are one-shot).
  bit          s_rdy = 1'b1;
  bit          s_mw, s_xp, s_md, s_hr;
  int          s_mwc, s_xpc, s_mdc, s_hrc;
  logic [31:0] s_mwpc, s_xppc, s_hrpc;

  // Behavioural reference: state 0 run, 1 memory-wait, 2 hosted.
  int          m_st   [N];
  logic [31:0] m_pc   [N];
  longint      m_last [N];
  int          m_ptr;
  longint      cyc;

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R1";
  int    watch_ctx = -1;
  longint watch_t [$];
  longint wd = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int predict(input bit mw, input int mwc, input bit xp, input int xpc);
    int sel = -1;
    for (int k = 1; k <= N; k++) begin
      int c = (m_ptr + k) % N;
      if (sel < 0 && m_st[c] == 0 && (cyc - m_last[c]) >= D &&
          !(mw && mwc == c) && !(xp && xpc == c)) sel = c;
    end
    return sel;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < N; c++) begin
      m_st[c] = 0; m_pc[c] = 32'h0; m_last[c] = -D;
    end
    m_ptr = N - 1;
    cyc = 0;
  endtask

  task automatic step();
    int  sel;
    bit  fire;
    bit  mw, xp, md, hr;
    int  mwc, xpc, mdc, hrc;
    logic [31:0] mwpc, xppc, hrpc;
    longint act, exp;
    @(negedge clk);
    mw = s_mw; xp = s_xp; md = s_md; hr = s_hr;
    mwc = s_mwc; xpc = s_xpc; mdc = s_mdc; hrc = s_hrc;
    mwpc = s_mwpc; xppc = s_xppc; hrpc = s_hrpc;
    issue_ready    = s_rdy;
    mw_req_valid   = mw; mw_req_ctx = IW'(mwc); mw_req_pc = mwpc;
    xp_req_valid   = xp; xp_req_ctx = IW'(xpc); xp_req_pc = xppc;
    mem_done_valid = md; mem_done_ctx = IW'(mdc);
    host_ret_valid = hr; host_ret_ctx = IW'(hrc); host_ret_pc = hrpc;
    s_mw = 0; s_xp = 0; s_md = 0; s_hr = 0;
    #1;
    sel = predict(mw, mwc, xp, xpc);
    exp = (sel >= 0) ? {1'b1, 4'(sel), m_pc[sel]} : 37'h0;
    act = issue_valid ? {1'b1, issue_ctx, issue_pc} : 37'h0;
    check(act == exp, cur_req, "offer{valid,ctx,pc}", act, exp);
    fire = (sel >= 0) && s_rdy;
    if (issue_valid && issue_ready && watch_ctx >= 0 && int'(issue_ctx) == watch_ctx)
      watch_t.push_back(cyc);
    @(posedge clk);
    if (fire) begin
      m_pc[sel] = m_pc[sel] + STEP; m_last[sel] = cyc; m_ptr = sel;
    end
    if (hr && m_st[hrc] == 2) begin m_st[hrc] = 0; m_pc[hrc] = hrpc; end
    if (md && m_st[mdc] == 1) m_st[mdc] = 0;
    if (mw) begin m_st[mwc] = 1; m_pc[mwc] = mwpc; end
    if (xp) begin m_st[xpc] = 2; m_pc[xpc] = xppc; end
    cyc++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    issue_ready = 0; mw_req_valid = 0; xp_req_valid = 0;
    mem_done_valid = 0; host_ret_valid = 0;
    mw_req_ctx = '0; xp_req_ctx = '0; mem_done_ctx = '0; host_ret_ctx = '0;
    mw_req_pc = '0; xp_req_pc = '0; host_ret_pc = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(issue_valid == 1'b0, "R1", "valid in reset", issue_valid, 0);
    rst_n = 1'b1;
    #1;
    check(issue_valid && issue_ctx == 0 && issue_pc == 0, "R1", "first offer",
          {issue_valid, issue_ctx}, {1'b1, 4'd0});

    // R2 R3 R4: free rotation, every context runnable.
    cur_req = "R2"; run(40);

    // R5 R6: park one context for memory and another for the host.
    cur_req = "R5";
    s_mw = 1; s_mwc = 3; s_mwpc = 32'h100;
    s_xp = 1; s_xpc = 5; s_xppc = 32'h200;
    run(30);
    s_md = 1; s_mdc = 3; run(20);
    cur_req = "R6";
    s_hr = 1; s_hrc = 5; s_hrpc = 32'h300; run(20);

    // R7: completions that do not match the state are ignored.
    cur_req = "R7";
    s_md = 1; s_mdc = 8; run(3);
    s_mw = 1; s_mwc = 9; s_mwpc = 32'h900; run(2);
    s_hr = 1; s_hrc = 9; s_hrpc = 32'hBAD0; run(3);
    s_md = 1; s_mdc = 9; run(2);
    s_xp = 1; s_xpc = 10; s_xppc = 32'hA00; run(2);
    s_md = 1; s_mdc = 10; run(20);
    s_hr = 1; s_hrc = 10; s_hrpc = 32'hA40; run(20);

    // R3: only one context left runnable -> one transfer every D cycles.
    cur_req = "R3";
    for (int c = 0; c < N; c++) if (c != 7) begin s_mw = 1; s_mwc = c; s_mwpc = 32'h1000 + c; step(); end
    watch_ctx = 7; watch_t.delete();
    run(50);
    check(watch_t.size() >= 3 && (watch_t[2] - watch_t[1]) == D, "R3", "gap between issues",
          (watch_t.size() >= 3) ? watch_t[2] - watch_t[1] : -1, D);
    watch_ctx = -1;
    for (int c = 0; c < N; c++) if (c != 7) begin s_md = 1; s_mdc = c; step(); end
    run(20);

    // R8: park exactly the context that would be offered.
    cur_req = "R8";
    for (int i = 0; i < 6; i++) begin
      int p = predict(0, 0, 0, 0);
      if (p >= 0) begin s_mw = 1; s_mwc = p; s_mwpc = 32'h2000 + p; end
      step();
      if (p >= 0) begin s_md = 1; s_mdc = p; end
      step();
    end
    run(10);

    // R10: park and completion for the same context in one cycle.
    cur_req = "R10";
    s_mw = 1; s_mwc = 2; s_mwpc = 32'h3000; run(2);
    s_xp = 1; s_xpc = 2; s_xppc = 32'h3100; s_md = 1; s_mdc = 2; run(20);
    check(m_st[2] == 2, "R10", "park wins over completion (model)", m_st[2], 2);
    s_hr = 1; s_hrc = 2; s_hrpc = 32'h3200; run(20);

    // R9: back-pressure.
    cur_req = "R9";
    s_rdy = 0; run(8);
    for (int i = 0; i < 200; i++) begin s_rdy = ($urandom % 3) != 0; step(); end
    s_rdy = 1;

    // Mixed random traffic on every input.
    cur_req = "R2";
    for (int i = 0; i < 3000; i++) begin
      s_rdy = ($urandom % 5) != 0;
      if ($urandom % 6 == 0) begin s_mw = 1; s_mwc = $urandom % N; s_mwpc = $urandom & ~32'h3; end
      if ($urandom % 9 == 0) begin
        s_xp = 1; s_xpc = $urandom % N; s_xppc = $urandom & ~32'h3;
        if (s_mw && s_xpc == s_mwc) s_xp = 0;
      end
      if ($urandom % 3 == 0) begin s_md = 1; s_mdc = $urandom % N; end
      if ($urandom % 4 == 0) begin s_hr = 1; s_hrc = $urandom % N; s_hrpc = $urandom & ~32'h3; end
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule